// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit carries out the instruction that sets the vector length and the maximum vector length of a scalable-vector processor. Instruction decode hands it the destination and source register indices, a 7-bit immediate, three control bits (update the maximum, update the length, vertical-first mode) and a record-condition bit. The register file supplies the value of the source register, and the loop-count register is supplied as a plain port. The unit holds the 64-bit vector state register. When an instruction is presented, the unit works out the new maximum and the new length and commits them to the state register on the next clock edge. In the same cycle it raises a write to the destination register and, when the instruction asks for it, a condition result.

Which source feeds the length depends on which register indices are zero. A non-zero source index selects the register value. When both indices are zero the immediate is used. When only the destination index is non-zero the count register is used. A register or count value above 127 saturates to 127. Any length above the maximum is clamped to the maximum. Either event raises an overflow flag, which is reported as the summary-overflow bit of the condition result.

Top module: `vlen_set_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `state_q` equals the `RESET_STATE` parameter and both `rt_we` and `cr_valid` are 0.
- R2: The effective immediate is `imm+1` taken modulo 128. With `set_max`=1 the maximum field (`state_q[63:57]`) becomes the effective immediate. With `set_max`=0 the maximum field keeps its value.
- R3: With `set_len`=0 the length field (`state_q[56:50]`) keeps its value, subject only to the clamp of R8. This holds for the read-length form (`rt_idx`≠0, `ra_idx`=0, `set_max`=0, `set_len`=0), which leaves the state unchanged.
- R4: With `set_len`=1 and `ra_idx`≠0, the length source is `ra_val`.
- R5: With `set_len`=1, `ra_idx`=0 and `rt_idx`=0, the length source is the effective immediate.
- R6: With `set_len`=1, `ra_idx`=0 and `rt_idx`≠0, the length source is `cnt_val`.
- R7: A register or count source value above 127 (unsigned) is taken as 127 and sets the overflow flag. Exactly 127 does not set the flag.
- R8: A length greater than the new maximum is replaced by the maximum and sets the overflow flag. The length field therefore never exceeds the maximum field.
- R9: One cycle after an instruction with `rt_idx`≠0, `rt_we` is 1 for one cycle, `rt_addr`=`rt_idx`, and `rt_data` is the final length zero-extended to 64 bits. With `rt_idx`=0, `rt_we` stays 0.
- R10: With `set_max`=1, the vertical-first bit (`state_q[0]`) is loaded from `vfirst_in` and the persist bit (`state_q[1]`) is cleared. With `set_max`=0 both bits keep their values. Every state bit from 49 down to 2 always keeps its value.
- R11: One cycle after an instruction with `rc`=1, `cr_valid` is 1 for one cycle, whatever the value of `rt_idx`. `cr_field` is {lt, gt, eq, so} from bit 3 down to bit 0, where lt=0, gt=(length≠0), eq=(length=0) and so is the overflow flag. With `rc`=0, `cr_valid` stays 0.
- R12: A cycle with `valid`=0 changes no state bit and raises neither `rt_we` nor `cr_valid`.
- R13: An immediate of 127 gives an effective value of 0. It can set the maximum, or the length, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | An instruction is presented this cycle |
| rt_idx | input | 5 | Destination register index |
| ra_idx | input | 5 | Source register index |
| imm | input | 7 | Immediate field (effective value is field plus one) |
| set_max | input | 1 | Update the maximum vector length and the mode bits |
| set_len | input | 1 | Update the vector length |
| vfirst_in | input | 1 | Vertical-first value loaded when `set_max`=1 |
| rc | input | 1 | Produce a condition result |
| ra_val | input | 64 | Value of the source register |
| cnt_val | input | 64 | Value of the loop-count register |
| state_q | output | 64 | Vector state register |
| rt_we | output | 1 | Destination register write enable |
| rt_addr | output | 5 | Destination register index for the write |
| rt_data | output | 64 | Zero-extended final length |
| cr_valid | output | 1 | Condition result valid |
| cr_field | output | 4 | {lt, gt, eq, so} |

## Verification
The bench covers each of the three source-selection cases, and each of them with the destination index both zero and non-zero. A design that decoded the index tests the wrong way round would load the count where the immediate belongs. The bench drives register and count values just above 127, exactly 127 and far above 2^32. A saturation check that looked only at the low bits would truncate instead of saturating, and a `>=` comparison would flag 127 as overflow. Other cases target the wrap of the immediate to zero, clamping when the maximum shrinks under an unchanged length, and the read-length form. A design that wrote the state on those instructions would disturb the mode bits or the length. A design that gated the condition result on the destination index would miss `cr_valid` when that index is zero.

// File: rtl/vls_pkg.sv
package vls_pkg;
  // Condition result, most significant bit first
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } vls_cr_t;
endpackage

// File: rtl/vls_sat.sv
// Saturate a wide unsigned value to LW bits, flagging the saturation
module vls_sat #(
  parameter int XLEN = 64,
  parameter int LW   = 7
) (
  input  logic [XLEN-1:0] din,
  output logic [LW-1:0]   dout,
  output logic            sat
);
  always_comb begin
    sat  = |din[XLEN-1:LW];
    dout = sat ? {LW{1'b1}} : din[LW-1:0];
  end
endmodule

// File: rtl/vls_src_sel.sv
// Picks the raw length from the immediate, the source register or the count
module vls_src_sel #(
  parameter int XLEN = 64,
  parameter int LW   = 7,
  parameter int AW   = 5
) (
  input  logic            set_len,
  input  logic [AW-1:0]   rt_idx,
  input  logic [AW-1:0]   ra_idx,
  input  logic [LW-1:0]   imm_eff,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] cnt_val,
  input  logic [LW-1:0]   cur_len,
  output logic [LW-1:0]   len_raw,
  output logic            sat_ov
);
  localparam int NSRC = 2;

  logic [XLEN-1:0] wide_in  [NSRC];
  logic [LW-1:0]   narrow   [NSRC];
  logic [NSRC-1:0] sat_flag;

  assign wide_in[0] = ra_val;
  assign wide_in[1] = cnt_val;

  // The two register-sourced paths share one saturating stage shape
  for (genvar g = 0; g < NSRC; g++) begin : g_sat
    vls_sat #(.XLEN(XLEN), .LW(LW)) u_sat (
      .din  (wide_in[g]),
      .dout (narrow[g]),
      .sat  (sat_flag[g])
    );
  end

  logic ra_nz, rt_nz;
  assign ra_nz = |ra_idx;
  assign rt_nz = |rt_idx;

  always_comb begin
    len_raw = cur_len;
    sat_ov  = 1'b0;
    if (set_len) begin
      if (ra_nz) begin
        len_raw = narrow[0];
        sat_ov  = sat_flag[0];
      end else if (!rt_nz) begin
        len_raw = imm_eff;
      end else begin
        len_raw = narrow[1];
        sat_ov  = sat_flag[1];
      end
    end
  end
endmodule

// File: rtl/vls_clamp.sv
// Bounds the length by the maximum
module vls_clamp #(
  parameter int LW = 7
) (
  input  logic [LW-1:0] len_raw,
  input  logic [LW-1:0] max_len,
  output logic [LW-1:0] len_out,
  output logic          clamp_ov
);
  always_comb begin
    clamp_ov = len_raw > max_len;
    len_out  = clamp_ov ? max_len : len_raw;
  end
endmodule

// File: rtl/vlen_set_unit.sv
module vlen_set_unit #(
  parameter int          XLEN        = 64,
  parameter int          LW          = 7,
  parameter int          AW          = 5,
  parameter logic [63:0] RESET_STATE = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic [AW-1:0]   rt_idx,
  input  logic [AW-1:0]   ra_idx,
  input  logic [LW-1:0]   imm,
  input  logic            set_max,
  input  logic            set_len,
  input  logic            vfirst_in,
  input  logic            rc,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] cnt_val,
  output logic [XLEN-1:0] state_q,
  output logic            rt_we,
  output logic [AW-1:0]   rt_addr,
  output logic [XLEN-1:0] rt_data,
  output logic            cr_valid,
  output logic [3:0]      cr_field
);
  import vls_pkg::*;

  // Field placement: bit 0 of the big-endian view is bit XLEN-1 here
  localparam int MAX_HI  = XLEN - 1;
  localparam int MAX_LO  = XLEN - LW;
  localparam int LEN_HI  = MAX_LO - 1;
  localparam int LEN_LO  = XLEN - 2 * LW;
  localparam int VF_BIT  = 0;
  localparam int PST_BIT = 1;

  logic [LW-1:0] imm_eff, max_new, len_raw, len_fin;
  logic          sat_ov, clamp_ov, ovf;
  logic [XLEN-1:0] state_nxt;
  vls_cr_t       cr_nxt;

  assign imm_eff = imm + LW'(1);
  assign max_new = set_max ? imm_eff : state_q[MAX_HI:MAX_LO];

  vls_src_sel #(.XLEN(XLEN), .LW(LW), .AW(AW)) u_src (
    .set_len (set_len),
    .rt_idx  (rt_idx),
    .ra_idx  (ra_idx),
    .imm_eff (imm_eff),
    .ra_val  (ra_val),
    .cnt_val (cnt_val),
    .cur_len (state_q[LEN_HI:LEN_LO]),
    .len_raw (len_raw),
    .sat_ov  (sat_ov)
  );

  vls_clamp #(.LW(LW)) u_clamp (
    .len_raw  (len_raw),
    .max_len  (max_new),
    .len_out  (len_fin),
    .clamp_ov (clamp_ov)
  );

  assign ovf = sat_ov | clamp_ov;

  always_comb begin
    state_nxt                = state_q;
    state_nxt[MAX_HI:MAX_LO] = max_new;
    state_nxt[LEN_HI:LEN_LO] = len_fin;
    if (set_max) begin
      state_nxt[VF_BIT]  = vfirst_in;
      state_nxt[PST_BIT] = 1'b0;
    end
    cr_nxt.lt = 1'b0;
    cr_nxt.gt = |len_fin;
    cr_nxt.eq = ~|len_fin;
    cr_nxt.so = ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= RESET_STATE[XLEN-1:0];
      rt_we    <= 1'b0;
      rt_addr  <= '0;
      rt_data  <= '0;
      cr_valid <= 1'b0;
      cr_field <= '0;
    end else begin
      rt_we    <= valid && (|rt_idx);
      cr_valid <= valid && rc;
      if (valid) begin
        state_q  <= state_nxt;
        rt_addr  <= rt_idx;
        rt_data  <= {{(XLEN-LW){1'b0}}, len_fin};
        cr_field <= cr_nxt;
      end
    end
  end
endmodule

// File: rtl/vls_chk.sv
module vls_chk #(
  parameter int XLEN = 64,
  parameter int LW   = 7,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            valid,
  input logic            set_max,
  input logic            rc,
  input logic [XLEN-1:0] state_q,
  input logic            rt_we,
  input logic [AW-1:0]   rt_addr,
  input logic [XLEN-1:0] rt_data,
  input logic            cr_valid,
  input logic [3:0]      cr_field
);
  localparam int MAX_LO = XLEN - LW;
  localparam int LEN_LO = XLEN - 2 * LW;

  p_len_le_max_r8: assert property (@(posedge clk) disable iff (rst)
    state_q[LEN_LO +: LW] <= state_q[MAX_LO +: LW]);

  p_rt_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    rt_we |-> (rt_addr != '0));

  p_rt_zero_ext_r9: assert property (@(posedge clk) disable iff (rst)
    rt_we |-> (rt_data[XLEN-1:LW] == '0));

  p_cr_shape_r11: assert property (@(posedge clk) disable iff (rst)
    cr_valid |-> (!cr_field[3] && (cr_field[2] != cr_field[1])));

  p_cr_follows_rc_r11: assert property (@(posedge clk) disable iff (rst)
    (valid && rc) |=> cr_valid);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(state_q) && !rt_we && !cr_valid));

  p_persist_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (valid && set_max) |=> !state_q[1]);

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (valid && !set_max) |=> $stable(state_q[1:0]));
endmodule

bind vlen_set_unit vls_chk #(.XLEN(XLEN), .LW(LW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .valid    (valid),
  .set_max  (set_max),
  .rc       (rc),
  .state_q  (state_q),
  .rt_we    (rt_we),
  .rt_addr  (rt_addr),
  .rt_data  (rt_data),
  .cr_valid (cr_valid),
  .cr_field (cr_field)
);

// File: tb/sim_vlen_set_unit.sv
`timescale 1ns/1ps
module sim_vlen_set_unit;
  localparam logic [63:0] RST_ST = 64'h0001_2345_6789_ABC3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [4:0]  rt_idx = '0, ra_idx = '0;
  logic [6:0]  imm = '0;
  logic        set_max = 1'b0, set_len = 1'b0, vfirst_in = 1'b0, rc = 1'b0;
  logic [63:0] ra_val = '0, cnt_val = '0;
  logic [63:0] state_q, rt_data;
  logic        rt_we, cr_valid;
  logic [4:0]  rt_addr;
  logic [3:0]  cr_field;

  always #4 clk = ~clk;

  vlen_set_unit #(.RESET_STATE(RST_ST)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1", exp_tag = "R1";

  // Reference model
  logic [63:0] m_state;
  logic        m_we, m_crv;
  logic [4:0]  m_addr;
  logic [63:0] m_data;
  logic [3:0]  m_cr;

  always @(posedge clk) begin
    if (rst) begin
      m_state = RST_ST; m_we = 0; m_crv = 0; exp_tag = "R1";
    end else begin
      exp_tag = cur_tag;
      m_we = valid && (rt_idx != 0);
      m_crv = valid && rc;
      if (valid) begin
        int mx, ln, eff;
        bit ov;
        ov = 0;
        eff = (int'(imm) + 1) % 128;
        mx = set_max ? eff : int'(m_state[63:57]);
        if (!set_len) ln = int'(m_state[56:50]);
        else if (ra_idx != 0) begin
          if (ra_val > 64'd127) begin ln = 127; ov = 1; end else ln = int'(ra_val);
        end else if (rt_idx == 0) ln = eff;
        else begin
          if (cnt_val > 64'd127) begin ln = 127; ov = 1; end else ln = int'(cnt_val);
        end
        if (ln > mx) begin ln = mx; ov = 1; end
        m_state[63:57] = 7'(mx);
        m_state[56:50] = 7'(ln);
        if (set_max) begin m_state[0] = vfirst_in; m_state[1] = 1'b0; end
        m_addr = rt_idx;
        m_data = 64'(ln);
        m_cr = {1'b0, ln != 0, ln == 0, ov};
      end
    end
  end

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", exp_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check("state", state_q, m_state);
    check("rt_we", 64'(rt_we), 64'(m_we));
    check("cr_valid", 64'(cr_valid), 64'(m_crv));
    if (m_we) begin
      check("rt_addr", 64'(rt_addr), 64'(m_addr));
      check("rt_data", rt_data, m_data);
    end
    if (m_crv) check("cr_field", 64'(cr_field), 64'(m_cr));
  end

  task automatic issue(input string tag, input logic [4:0] rt, input logic [4:0] ra,
                       input logic [6:0] im, input logic ms, input logic vs,
                       input logic vf, input logic r, input logic [63:0] rv,
                       input logic [63:0] cv);
    @(negedge clk);
    cur_tag = tag;
    valid = 1; rt_idx = rt; ra_idx = ra; imm = im; set_max = ms; set_len = vs;
    vfirst_in = vf; rc = r; ra_val = rv; cnt_val = cv;
    @(negedge clk);
    valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2 R10: maximum 8, vertical-first on, persist cleared
    issue("R2", 0, 0, 7'd7, 1, 0, 1, 1, 0, 0);
    // R5: immediate source, 4+1
    issue("R5", 0, 0, 7'd4, 0, 1, 0, 1, 0, 0);
    // R8: immediate 21 above maximum 8
    issue("R8", 0, 0, 7'd20, 0, 1, 0, 1, 0, 0);
    // R4: register source, destination zero and non-zero
    issue("R4", 0, 5'd3, 7'd0, 0, 1, 0, 1, 64'd6, 0);
    issue("R4", 5'd9, 5'd3, 7'd0, 0, 1, 0, 0, 64'd2, 64'd99);
    // R2 R10: maximum 127, vertical-first off
    issue("R2", 0, 0, 7'd126, 1, 0, 0, 0, 0, 0);
    // R7: saturation on register and on count
    issue("R7", 5'd4, 5'd3, 7'd0, 0, 1, 0, 1, 64'd1000, 0);
    issue("R7", 5'd4, 5'd3, 7'd0, 0, 1, 0, 1, 64'd127, 0);
    issue("R7", 5'd4, 5'd3, 7'd0, 0, 1, 0, 1, 64'd128, 0);
    issue("R7", 5'd5, 0, 7'd0, 0, 1, 0, 1, 0, 64'h0000_0100_0000_0001);
    // R6: count source
    issue("R6", 5'd5, 0, 7'd3, 0, 1, 0, 1, 64'd77, 64'd50);
    // R3: read-length form leaves state unchanged
    issue("R3", 5'd7, 0, 7'd9, 0, 0, 1, 1, 64'd3, 64'd3);
    // R12: fields toggle without valid
    @(negedge clk);
    cur_tag = "R12";
    rt_idx = 5'd1; ra_idx = 5'd2; imm = 7'd1; set_max = 1; set_len = 1; rc = 1;
    repeat (3) @(negedge clk);
    // R8: shrink maximum under unchanged length
    issue("R8", 0, 0, 7'd9, 1, 0, 1, 1, 0, 0);
    // R13: immediate 127 wraps to zero maximum, length clamps to zero
    issue("R13", 5'd2, 0, 7'd127, 1, 1, 0, 1, 0, 0);
    issue("R13", 0, 0, 7'd127, 0, 1, 0, 1, 0, 0);
    // R9 R11: no register write with destination zero, condition still produced
    issue("R9", 0, 0, 7'd0, 1, 1, 1, 1, 0, 0);
    issue("R11", 5'd31, 5'd31, 7'd63, 0, 1, 0, 0, 64'd40, 0);
    // Mixed patterns
    for (int i = 0; i < 300; i++) begin
      logic [63:0] rv, cv;
      rv = ($urandom % 4 == 0) ? {$urandom, $urandom} : 64'($urandom % 200);
      cv = ($urandom % 4 == 0) ? {$urandom, $urandom} : 64'($urandom % 200);
      issue("R10", 5'($urandom % 3), 5'($urandom % 3), 7'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), rv, cv);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule